// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits in the execute stage of a 32-bit core. It decodes a single-data-transfer instruction word and computes the memory address that the transfer will use. It also computes the value to write back into the base register and whether that write-back happens. Alongside these it produces the flags that steer the access: byte or word size, load or store direction, a forced user-privilege access and an undefined-instruction indication.

Register values arrive already read. The caller supplies the base value, the offset-register value, the address of the current instruction and the carry flag. When `in_valid` is high, all results are captured on the next rising clock edge. They then hold until the next strobe.

The offset comes from one of two sources. It is either a 12-bit immediate, or an offset-register value passed through a constant barrel shift. The offset is added to or subtracted from the base. The access uses either the computed address (pre-indexed) or the untouched base (post-indexed).

Top module: `ldst_agu`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge.
- R2: When `in_valid` is low at a rising edge, every output keeps its previous value, whatever the other inputs carry.
- R3: When insn[25] is 0, the offset is insn[11:0] zero-extended to 32 bits.
- R4: When insn[25] is 1 and insn[4] is 0, the offset is `ofs_val` shifted by the 5-bit amount in insn[11:7]. The shift kind is insn[6:5]: 0 shift left, 1 logical right, 2 arithmetic right, 3 rotate right. An amount of zero is special for three of these kinds. Logical right with amount 0 gives 0. Arithmetic right with amount 0 gives 32 copies of bit 31. Rotate right with amount 0 gives {carry_in, ofs_val[31:1]}. Shift left with amount 0 leaves the value unchanged.
- R5: The effective address is base + offset when insn[23] is 1 and base − offset when insn[23] is 0, both modulo 2^32. `wb_data` always carries the effective address of a defined instruction.
- R6: When insn[19:16] equals 15, the base used is `pc_val` + 8 instead of `base_val`.
- R7: `acc_addr` is the effective address when insn[24] is 1 (pre-indexed) and the unmodified base when insn[24] is 0 (post-indexed).
- R8: Before the suppression in R9 is applied, `wb_en` is 1 for every post-indexed transfer, and 1 for a pre-indexed transfer only when insn[21] is 1.
- R9: `wb_en` is 0 for a load (insn[20] = 1) whose data register insn[15:12] equals its base register insn[19:16]. A store with equal indices still writes back.
- R10: `user_force` is 1 exactly when the transfer is post-indexed and insn[21] is 1.
- R11: When insn[25] and insn[4] are both 1, `undef` is 1 and every other output is 0. When either bit is 0, `undef` is 0.
- R12: `acc_load` equals insn[20] and `acc_byte` equals insn[22] for a defined instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the inputs below |
| insn | input | 32 | Transfer instruction word |
| base_val | input | 32 | Value of the base register |
| ofs_val | input | 32 | Value of the offset register |
| pc_val | input | 32 | Address of the current instruction |
| carry_in | input | 1 | Current carry flag |
| acc_addr | output | 32 | Address of the memory access |
| acc_byte | output | 1 | 1 for a byte access, 0 for a word access |
| acc_load | output | 1 | 1 for a load, 0 for a store |
| wb_data | output | 32 | Effective address for base write-back |
| wb_en | output | 1 | Base write-back enable |
| user_force | output | 1 | Access must use user privilege |
| undef | output | 1 | Undefined instruction; no transfer |

## Verification
There is a single register stage, so any decoding or arithmetic error appears on the outputs one edge after the strobe. The error is confined to the vector that caused it. A wrong shift kind or a mishandled zero amount corrupts `wb_data`, and in pre-indexed mode `acc_addr` as well. A wrong pre/post choice makes `acc_addr` differ from `wb_data` when it should match, or match when it should differ. A faulty capture enable shows up as outputs that drift while `in_valid` is low.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned IMM_W     = 12;
    localparam int unsigned AMT_W     = 5;
    localparam int unsigned REGIDX_W  = 4;
    localparam int unsigned PC_AHEAD  = 8;
    localparam logic [REGIDX_W-1:0] PC_INDEX = 4'hF;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_LRIGHT = 2'd1,
        SH_ARIGHT = 2'd2,
        SH_ROTATE = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wb_data;
        logic              wb_en;
        logic              user_force;
        logic              undef;
        logic              load;
        logic              is_byte;
    } agu_result_s;

endpackage

// File: rtl/agu_offset.sv
module agu_offset
    import agu_pkg::*;
(
    input  logic                 reg_form,
    input  logic [IMM_W-1:0]     imm_field,
    input  logic [WORD_W-1:0]    ofs_val,
    input  logic                 carry_in,
    output logic [WORD_W-1:0]    offset
);

    localparam int unsigned SH_W = AMT_W + 1;

    logic [AMT_W-1:0]  amt;
    shift_kind_e       kind;
    logic [SH_W-1:0]   back_amt;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        amt      = imm_field[IMM_W-1:IMM_W-AMT_W];
        kind     = shift_kind_e'(imm_field[6:5]);
        back_amt = SH_W'(WORD_W) - {1'b0, amt};
        shifted  = ofs_val;
        unique case (kind)
            SH_LEFT:   shifted = ofs_val << amt;
            SH_LRIGHT: shifted = (amt == '0) ? '0 : (ofs_val >> amt);
            SH_ARIGHT: shifted = (amt == '0) ? {WORD_W{ofs_val[WORD_W-1]}}
                                             : $unsigned($signed(ofs_val) >>> amt);
            SH_ROTATE: shifted = (amt == '0) ? {carry_in, ofs_val[WORD_W-1:1]}
                                             : ((ofs_val >> amt) | (ofs_val << back_amt));
            default:   shifted = ofs_val;
        endcase
        offset = reg_form ? shifted : {{(WORD_W-IMM_W){1'b0}}, imm_field};
    end

endmodule

// File: rtl/agu_addr.sv
module agu_addr
    import agu_pkg::*;
(
    input  logic [WORD_W-1:0] base_val,
    input  logic [WORD_W-1:0] pc_val,
    input  logic              base_is_pc,
    input  logic [WORD_W-1:0] offset,
    input  logic              add_dir,
    output logic [WORD_W-1:0] base_used,
    output logic [WORD_W-1:0] eff_addr
);

    always_comb begin
        base_used = base_is_pc ? (pc_val + WORD_W'(PC_AHEAD)) : base_val;
        eff_addr  = add_dir ? (base_used + offset) : (base_used - offset);
    end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [31:0]       base_val,
    input  logic [31:0]       ofs_val,
    input  logic [31:0]       pc_val,
    input  logic              carry_in,
    output logic [31:0]       acc_addr,
    output logic              acc_byte,
    output logic              acc_load,
    output logic [31:0]       wb_data,
    output logic              wb_en,
    output logic              user_force,
    output logic              undef
);

    logic                f_load, f_wback, f_byte, f_add, f_pre, f_regofs, f_bit4;
    logic [REGIDX_W-1:0] rn_idx, rd_idx;
    logic [WORD_W-1:0]   offset, base_used, eff_addr;
    logic                unused_fields;
    agu_result_s         res_d, res_q;

    assign f_load   = insn[20];
    assign f_wback  = insn[21];
    assign f_byte   = insn[22];
    assign f_add    = insn[23];
    assign f_pre    = insn[24];
    assign f_regofs = insn[25];
    assign f_bit4   = insn[4];
    assign rn_idx   = insn[19:16];
    assign rd_idx   = insn[15:12];
    assign unused_fields = ^{insn[31:26], insn[3:0]};

    agu_offset u_offset (
        .reg_form  (f_regofs),
        .imm_field (insn[IMM_W-1:0]),
        .ofs_val   (ofs_val),
        .carry_in  (carry_in),
        .offset    (offset)
    );

    agu_addr u_addr (
        .base_val   (base_val),
        .pc_val     (pc_val),
        .base_is_pc (rn_idx == PC_INDEX),
        .offset     (offset),
        .add_dir    (f_add),
        .base_used  (base_used),
        .eff_addr   (eff_addr)
    );

    always_comb begin
        res_d = res_q;
        if (in_valid) begin
            res_d = '0;
            if (f_regofs && f_bit4) begin
                res_d.undef = 1'b1;
            end else begin
                res_d.addr       = f_pre ? eff_addr : base_used;
                res_d.wb_data    = eff_addr;
                res_d.wb_en      = (!f_pre || f_wback) && !(f_load && (rd_idx == rn_idx));
                res_d.user_force = !f_pre && f_wback;
                res_d.load       = f_load;
                res_d.is_byte    = f_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign acc_addr   = res_q.addr;
    assign wb_data    = res_q.wb_data;
    assign wb_en      = res_q.wb_en;
    assign user_force = res_q.user_force;
    assign undef      = res_q.undef;
    assign acc_load   = res_q.load;
    assign acc_byte   = res_q.is_byte;

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(acc_addr) && $stable(wb_data) && $stable(wb_en)));

    a_r11_undef_quiet: assert property (@(posedge clk) disable iff (rst)
        undef |-> (!wb_en && !user_force && !acc_load && !acc_byte && acc_addr == '0));

    a_r7_pre_uses_eff: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(insn[24]) && !undef) |-> (acc_addr == wb_data));

    a_r8_post_store_writes: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(insn[24]) && !$past(insn[20]) && !undef) |-> wb_en);

    a_r10_user_needs_defined: assert property (@(posedge clk) disable iff (rst)
        user_force |-> (!undef && !(acc_addr == wb_data && $past(insn[24]))));

    a_r12_size_follows_insn: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !undef) |-> (acc_byte == $past(insn[22]) && acc_load == $past(insn[20])));

endmodule

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] wbd;
        logic        wbe;
        logic        usr;
        logic        und;
        logic        ld;
        logic        byt;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0, base_val = '0, ofs_val = '0, pc_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] acc_addr, wb_data;
    logic        acc_byte, acc_load, wb_en, user_force, undef;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ldst_agu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .base_val(base_val), .ofs_val(ofs_val), .pc_val(pc_val), .carry_in(carry_in),
        .acc_addr(acc_addr), .acc_byte(acc_byte), .acc_load(acc_load),
        .wb_data(wb_data), .wb_en(wb_en), .user_force(user_force), .undef(undef)
    );

    function automatic logic [31:0] shift_ref(logic [31:0] v, logic [1:0] k, logic [4:0] a, logic c);
        logic [63:0] dbl;
        dbl = {v, v} >> a;
        case (k)
            2'd0: return v << a;
            2'd1: return (a == 0) ? 32'd0 : v >> a;
            2'd2: return (a == 0) ? (v[31] ? 32'hFFFF_FFFF : 32'd0) : 32'($signed(v) >>> a);
            default: return (a == 0) ? {c, v[31:1]} : dbl[31:0];
        endcase
    endfunction

    function automatic exp_t model(logic [31:0] i, logic [31:0] b, logic [31:0] o,
                                   logic [31:0] p, logic c);
        exp_t e;
        logic [31:0] bb, off, eff;
        e = '0;
        if (i[25] && i[4]) begin
            e.und = 1'b1;
            return e;
        end
        bb  = (i[19:16] == 4'd15) ? p + 32'd8 : b;
        off = i[25] ? shift_ref(o, i[6:5], i[11:7], c) : {20'd0, i[11:0]};
        eff = i[23] ? bb + off : bb + (~off + 32'd1);
        e.addr = i[24] ? eff : bb;
        e.wbd  = eff;
        e.wbe  = (!i[24] || i[21]) && !(i[20] && (i[15:12] == i[19:16]));
        e.usr  = !i[24] && i[21];
        e.ld   = i[20];
        e.byt  = i[22];
        return e;
    endfunction

    function automatic logic [31:0] mk(bit pre, bit add, bit byt, bit w, bit ld,
                                       logic [3:0] rn, logic [3:0] rd, bit regf, logic [11:0] low);
        return {4'hE, 2'b01, regf, pre, add, byt, w, ld, rn, rd, low};
    endfunction

    task automatic chk1(string tag, string fld, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, fld, got, exp);
        end
    endtask

    task automatic compare(string tag, exp_t e);
        chk1({tag, " R7"},  "acc_addr",   acc_addr, e.addr);
        chk1({tag, " R5"},  "wb_data",    wb_data, e.wbd);
        chk1({tag, " R8"},  "wb_en",      {31'd0, wb_en}, {31'd0, e.wbe});
        chk1({tag, " R10"}, "user_force", {31'd0, user_force}, {31'd0, e.usr});
        chk1({tag, " R11"}, "undef",      {31'd0, undef}, {31'd0, e.und});
        chk1({tag, " R12"}, "acc_load",   {31'd0, acc_load}, {31'd0, e.ld});
        chk1({tag, " R12"}, "acc_byte",   {31'd0, acc_byte}, {31'd0, e.byt});
    endtask

    task automatic apply(string tag, logic [31:0] i, logic [31:0] b, logic [31:0] o,
                         logic [31:0] p, logic c);
        @(negedge clk);
        insn = i; base_val = b; ofs_val = o; pc_val = p; carry_in = c; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        compare(tag, model(i, b, o, p, c));
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t last;
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset", '0);
        @(negedge clk);
        rst = 1'b0;

        // R3 immediate offset, pre-index add
        apply("R3 imm", mk(1,1,0,0,1,4'd2,4'd3,0,12'hFFF), 32'h1000, 32'h0, 32'h0, 0);
        // R5 wrap on subtract and add
        apply("R5 sub-wrap", mk(1,0,0,1,0,4'd1,4'd1,0,12'd8), 32'd4, 32'h0, 32'h0, 0);
        apply("R5 add-wrap", mk(1,1,1,1,0,4'd1,4'd2,0,12'h20), 32'hFFFF_FFF0, 32'h0, 32'h0, 0);
        // R6 base is program counter
        apply("R6 pc-base", mk(1,1,0,0,1,4'd15,4'd0,0,12'h4), 32'hDEAD_0000, 32'h0, 32'h100, 0);
        // R4 shifts: zero and nonzero amounts for each kind
        apply("R4 lsl0",  mk(1,1,0,0,0,4'd1,4'd2,1,{5'd0,2'd0,1'b0,4'd3}), 32'h100, 32'h8000_0001, 0, 0);
        apply("R4 lsl4",  mk(1,1,0,0,0,4'd1,4'd2,1,{5'd4,2'd0,1'b0,4'd3}), 32'h100, 32'h8000_0001, 0, 0);
        apply("R4 lsr0",  mk(1,1,0,0,0,4'd1,4'd2,1,{5'd0,2'd1,1'b0,4'd3}), 32'h100, 32'hFFFF_FFFF, 0, 0);
        apply("R4 lsr3",  mk(1,1,0,0,0,4'd1,4'd2,1,{5'd3,2'd1,1'b0,4'd3}), 32'h100, 32'h8000_0000, 0, 0);
        apply("R4 asr0",  mk(1,1,0,0,0,4'd1,4'd2,1,{5'd0,2'd2,1'b0,4'd3}), 32'h100, 32'h8000_0000, 0, 0);
        apply("R4 asr7",  mk(1,0,0,0,0,4'd1,4'd2,1,{5'd7,2'd2,1'b0,4'd3}), 32'h100, 32'h8000_0000, 0, 0);
        apply("R4 rrx",   mk(1,1,0,0,0,4'd1,4'd2,1,{5'd0,2'd3,1'b0,4'd3}), 32'h0, 32'h0000_0003, 0, 1);
        apply("R4 ror8",  mk(1,1,0,0,0,4'd1,4'd2,1,{5'd8,2'd3,1'b0,4'd3}), 32'h0, 32'h1234_5678, 0, 0);
        // R7 / R10 post-index with and without W
        apply("R7 post",  mk(0,1,0,0,0,4'd5,4'd6,0,12'h10), 32'h2000, 0, 0, 0);
        apply("R10 post-w", mk(0,1,0,1,1,4'd5,4'd6,0,12'h10), 32'h2000, 0, 0, 0);
        // R8 pre-index without W
        apply("R8 pre-now", mk(1,0,0,0,0,4'd5,4'd6,0,12'h10), 32'h2000, 0, 0, 0);
        // R9 load into own base suppresses; store does not
        apply("R9 ld-same", mk(0,1,0,1,1,4'd7,4'd7,0,12'h4), 32'h3000, 0, 0, 0);
        apply("R9 st-same", mk(0,1,0,0,0,4'd7,4'd7,0,12'h4), 32'h3000, 0, 0, 0);
        // R11 undefined form
        apply("R11 undef", mk(1,1,1,1,1,4'd1,4'd2,1,12'h0F0), 32'h4000, 32'h5, 0, 1);
        // R2 hold: new inputs without strobe
        apply("R2 prime", mk(1,1,0,1,0,4'd3,4'd4,0,12'h44), 32'h5000, 0, 0, 0);
        last = model(mk(1,1,0,1,0,4'd3,4'd4,0,12'h44), 32'h5000, 0, 0, 0);
        @(negedge clk);
        insn = mk(0,0,1,1,1,4'd9,4'd9,1,12'h0F0); base_val = 32'h9999; ofs_val = 32'h7;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        compare("R2 hold", last);

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] ri;
            ri = $urandom();
            if (($urandom() % 8) != 0) ri[4] = 1'b0;
            if (($urandom() % 6) == 0) ri[19:16] = 4'd15;
            if (($urandom() % 5) == 0) ri[15:12] = ri[19:16];
            apply("rand", ri, $urandom(), $urandom(), $urandom(), 1'($urandom()));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule